// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block is the clock-control sequencer inside a processor bus interface. An outside agent asks the processor to enter a low-power grant state by raising a stop-clock request. The controller waits for any bus cycle already in flight to finish. It then puts a dedicated announcement cycle on the bus, with a fixed address and control code and a one-clock address strobe. When either ready input answers that cycle, the controller settles into the grant state.

In the grant state the data and parity lines are released. The address strobe and lock are driven inactive. The address and control lines stay at the level they carried when the state was entered. A bus hold request is still served in this state: the controller acknowledges it and floats the address and control group until the hold is released, then drives the same levels again. When the request is removed, a wake counter runs for a fixed number of clocks (a parameter limited to 10..20) before normal pass-through operation resumes. If the request comes back during that countdown, the controller announces itself again with a new cycle.

Top module: `stopclk_ctrl`

## Requirements
- R1: While reset is low and on the first clock after it, `state_o` is 2'b00 (normal), `hlda_o` is 0, and `addr_o` follows `addr_i`.
- R2: In normal state, a request with `cyc_busy_i` low moves `state_o` to 2'b01 (pending) at the next clock. In that first pending cycle, `ads_n_o` is 0, `addr_o` equals `SG_ADDR` and `ctl_o` equals `SG_CTL`.
- R3: While `cyc_busy_i` is high in normal state, a request leaves `state_o` at 2'b00.
- R4: Pending moves to grant (`state_o` 2'b10) only after a clock at which `rdy_i` or `brdy_i` is high, counted from the second pending cycle on. A ready seen during the strobe cycle has no effect.
- R5: In grant and resuming (`state_o[1]` = 1), `data_oe_o` and `par_oe_o` are 0, and `ads_n_o` and `lock_n_o` are 1.
- R6: In grant and resuming, `addr_o` and `ctl_o` keep the values they had on entering grant, whatever `addr_i` does.
- R7: In grant, a high `hold_i` raises `hlda_o` one clock later. While `hlda_o` is 1, `addr_oe_o` and `ctl_oe_o` are 0.
- R8: After `hold_i` falls, `hlda_o` drops one clock later. The output enables come back, and `addr_o` and `ctl_o` show the values held before the hold.
- R9: With `hold_i` and `hlda_o` low, a grant-state clock that sees the request low enters resuming (2'b11). `state_o` returns to 2'b00 exactly `RESUME_CLKS` clocks after that edge. The grant state is never left while hold is acknowledged.
- R10: A request seen during resuming moves `state_o` to pending at the next clock, and a new strobe cycle is issued.
- R11: `hlda_o` is never 1 outside the grant state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_req_i | input | 1 | Stop-clock request, active high |
| cyc_busy_i | input | 1 | A bus cycle is in progress |
| rdy_i | input | 1 | Normal ready, active high |
| brdy_i | input | 1 | Burst ready, active high |
| hold_i | input | 1 | Bus hold request |
| addr_i | input | ADDR_W | Core address value |
| ctl_i | input | CTL_W | Core cycle-definition value |
| ads_n_i | input | 1 | Core address strobe, active low |
| lock_n_i | input | 1 | Core lock, active low |
| data_i | input | DATA_W | Core data value |
| par_i | input | PAR_W | Core data parity value |
| data_oe_i | input | 1 | Core data drive enable |
| addr_o | output | ADDR_W | Address pin value |
| addr_oe_o | output | 1 | Address drive enable |
| ctl_o | output | CTL_W | Cycle-definition pin value |
| ads_n_o | output | 1 | Address strobe pin, active low |
| lock_n_o | output | 1 | Lock pin, active low |
| ctl_oe_o | output | 1 | Drive enable for control, strobe and lock |
| data_o | output | DATA_W | Data pin value |
| par_o | output | PAR_W | Parity pin value |
| data_oe_o | output | 1 | Data drive enable |
| par_oe_o | output | 1 | Parity drive enable |
| hlda_o | output | 1 | Hold acknowledge |
| state_o | output | 2 | 00 normal, 01 pending, 10 grant, 11 resuming |

## Verification
The bench builds the block with `RESUME_CLKS` = 10, the lowest legal wake delay, so a full resume countdown fits in a short run and an off-by-one in the counter shows as a state change one clock early or late. Narrow 16-bit address and data buses and a recognisable `SG_ADDR` make the announcement values easy to tell apart from core traffic. These settings let one run cover deferral by a busy cycle, a ready that arrives during the strobe, hold during grant, hold during resume, and a request that returns during resume.

// File: rtl/stopclk_pkg.sv
// Shared types for the stop-clock controller.
// Assumes: state encoding is visible on the status output, so it is fixed here.
package stopclk_pkg;

    typedef enum logic [1:0] {
        SC_RUN   = 2'b00,
        SC_PEND  = 2'b01,
        SC_GRANT = 2'b10,
        SC_WAKE  = 2'b11
    } sc_state_e;

    localparam int unsigned WAKE_MIN = 10;
    localparam int unsigned WAKE_MAX = 20;

endpackage

// File: rtl/stopclk_wake_ctr.sv
// Wake delay counter: loads a fixed count and counts down while running.
// Assumes: load_i and run_i are never high together; expire_o flags the
// final counting clock so the sequencer can leave on that edge.
module stopclk_wake_ctr #(
    parameter int unsigned LOAD  = 12,
    parameter int unsigned CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expire_o
);

    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load on request release, step down while resuming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_V;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

    // Expiry flag: last clock of the countdown.
    always_comb begin
        expire_o = run_i && (cnt_q == ONE_V);
    end

endmodule

// File: rtl/stopclk_seq.sv
// Clock-control sequencer: normal, pending announcement, grant, resuming.
// Assumes: ready inputs are active high and are only meaningful after the
// strobe cycle; hold is served only in the grant state.
module stopclk_seq
    import stopclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req_i,
    input  logic      cyc_busy_i,
    input  logic      rdy_i,
    input  logic      brdy_i,
    input  logic      hold_i,
    input  logic      expire_i,
    output sc_state_e state_o,
    output logic      strobe_o,
    output logic      hlda_o,
    output logic      load_o,
    output logic      run_o
);

    sc_state_e state_q;
    logic      strobe_q;
    logic      hlda_q;
    logic      leave_grant;

    // Exit condition from grant: request gone and no hold in progress.
    always_comb begin
        leave_grant = (state_q == SC_GRANT) && !stop_req_i && !hold_i && !hlda_q;
        load_o      = leave_grant;
        run_o       = (state_q == SC_WAKE) && !stop_req_i;
    end

    // State, strobe and hold-acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SC_RUN;
            strobe_q <= 1'b0;
            hlda_q   <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            hlda_q   <= (state_q == SC_GRANT) && hold_i;
            unique case (state_q)
                SC_RUN: begin
                    if (stop_req_i && !cyc_busy_i) begin
                        state_q  <= SC_PEND;
                        strobe_q <= 1'b1;
                    end
                end
                SC_PEND: begin
                    if (!strobe_q && (rdy_i || brdy_i)) begin
                        state_q <= SC_GRANT;
                    end
                end
                SC_GRANT: begin
                    if (leave_grant) begin
                        state_q <= SC_WAKE;
                    end
                end
                SC_WAKE: begin
                    if (stop_req_i) begin
                        state_q  <= SC_PEND;
                        strobe_q <= 1'b1;
                    end else if (expire_i) begin
                        state_q <= SC_RUN;
                    end
                end
                default: state_q <= SC_RUN;
            endcase
        end
    end

    assign state_o  = state_q;
    assign strobe_o = strobe_q;
    assign hlda_o   = hlda_q;

endmodule

// File: rtl/stopclk_pins.sv
// Pin multiplexer: picks core values, announcement values or held levels
// and forms the drive enables for every pin group.
// Assumes: the held copy is taken every clock outside grant/resuming, so
// on entry to grant it holds the last levels driven.
module stopclk_pins
    import stopclk_pkg::*;
#(
    parameter int unsigned     ADDR_W  = 30,
    parameter int unsigned     CTL_W   = 3,
    parameter int unsigned     DATA_W  = 32,
    parameter int unsigned     PAR_W   = 4,
    parameter logic [ADDR_W-1:0] SG_ADDR = '0,
    parameter logic [CTL_W-1:0]  SG_CTL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sc_state_e         state_i,
    input  logic              strobe_i,
    input  logic              hlda_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic              ads_n_i,
    input  logic              lock_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [PAR_W-1:0]  par_i,
    input  logic              data_oe_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              ads_n_o,
    output logic              lock_n_o,
    output logic              ctl_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PAR_W-1:0]  par_o,
    output logic              data_oe_o,
    output logic              par_oe_o
);

    localparam int unsigned HELD_W = ADDR_W + CTL_W;

    logic [HELD_W-1:0] held_q;
    logic              bus_oe;

    // Held levels: track driven address/control until grant is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!state_i[1]) begin
            held_q <= {addr_o, ctl_o};
        end
    end

    // Output selection per state.
    always_comb begin
        addr_o    = addr_i;
        ctl_o     = ctl_i;
        ads_n_o   = ads_n_i;
        lock_n_o  = lock_n_i;
        data_oe_o = data_oe_i;
        par_oe_o  = data_oe_i;
        bus_oe    = 1'b1;
        unique case (state_i)
            SC_RUN: begin
            end
            SC_PEND: begin
                addr_o    = SG_ADDR;
                ctl_o     = SG_CTL;
                ads_n_o   = !strobe_i;
                lock_n_o  = 1'b1;
                data_oe_o = 1'b0;
                par_oe_o  = 1'b0;
            end
            default: begin
                addr_o    = held_q[HELD_W-1:CTL_W];
                ctl_o     = held_q[CTL_W-1:0];
                ads_n_o   = 1'b1;
                lock_n_o  = 1'b1;
                data_oe_o = 1'b0;
                par_oe_o  = 1'b0;
                bus_oe    = !hlda_i;
            end
        endcase
    end

    // Data and parity values pass through; only their enables change.
    assign data_o    = data_i;
    assign par_o     = par_i;
    assign addr_oe_o = bus_oe;
    assign ctl_oe_o  = bus_oe;

endmodule

// File: rtl/stopclk_ctrl.sv
// Top of the stop-clock controller: sequencer, wake counter and pin mux.
// Assumes: RESUME_CLKS lies in 10..20; the core supplies normal-state pin
// values and a busy flag for cycles already on the bus.
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 30,
    parameter int unsigned       CTL_W       = 3,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       PAR_W       = 4,
    parameter int unsigned       RESUME_CLKS = 12,
    parameter logic [ADDR_W-1:0] SG_ADDR     = ADDR_W'(4),
    parameter logic [CTL_W-1:0]  SG_CTL      = CTL_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req_i,
    input  logic              cyc_busy_i,
    input  logic              rdy_i,
    input  logic              brdy_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic              ads_n_i,
    input  logic              lock_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [PAR_W-1:0]  par_i,
    input  logic              data_oe_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              ads_n_o,
    output logic              lock_n_o,
    output logic              ctl_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PAR_W-1:0]  par_o,
    output logic              data_oe_o,
    output logic              par_oe_o,
    output logic              hlda_o,
    output logic [1:0]        state_o
);

    localparam int unsigned CNT_W = $clog2(WAKE_MAX + 1);

    if ((RESUME_CLKS < WAKE_MIN) || (RESUME_CLKS > WAKE_MAX)) begin : g_bad_wake
        $error("RESUME_CLKS outside 10..20");
    end

    sc_state_e state;
    logic      strobe;
    logic      hlda;
    logic      load;
    logic      run;
    logic      expire;

    stopclk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req_i (stop_req_i),
        .cyc_busy_i (cyc_busy_i),
        .rdy_i      (rdy_i),
        .brdy_i     (brdy_i),
        .hold_i     (hold_i),
        .expire_i   (expire),
        .state_o    (state),
        .strobe_o   (strobe),
        .hlda_o     (hlda),
        .load_o     (load),
        .run_o      (run)
    );

    stopclk_wake_ctr #(
        .LOAD  (RESUME_CLKS),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .run_i    (run),
        .expire_o (expire)
    );

    stopclk_pins #(
        .ADDR_W  (ADDR_W),
        .CTL_W   (CTL_W),
        .DATA_W  (DATA_W),
        .PAR_W   (PAR_W),
        .SG_ADDR (SG_ADDR),
        .SG_CTL  (SG_CTL)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .strobe_i  (strobe),
        .hlda_i    (hlda),
        .addr_i    (addr_i),
        .ctl_i     (ctl_i),
        .ads_n_i   (ads_n_i),
        .lock_n_i  (lock_n_i),
        .data_i    (data_i),
        .par_i     (par_i),
        .data_oe_i (data_oe_i),
        .addr_o    (addr_o),
        .addr_oe_o (addr_oe_o),
        .ctl_o     (ctl_o),
        .ads_n_o   (ads_n_o),
        .lock_n_o  (lock_n_o),
        .ctl_oe_o  (ctl_oe_o),
        .data_o    (data_o),
        .par_o     (par_o),
        .data_oe_o (data_oe_o),
        .par_oe_o  (par_oe_o)
    );

    assign hlda_o  = hlda;
    assign state_o = state;

endmodule

// File: rtl/stopclk_ctrl_chk.sv
// Property checker for the stop-clock controller, bound to the top.
// Assumes: only top-level ports are observed; the resume window is timed
// with a local counter instead of a long $past.
module stopclk_ctrl_chk #(
    parameter int unsigned RESUME_CLKS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_busy_i,
    input logic       rdy_i,
    input logic       brdy_i,
    input logic       hold_i,
    input logic       ads_n_o,
    input logic       lock_n_o,
    input logic       data_oe_o,
    input logic       par_oe_o,
    input logic       addr_oe_o,
    input logic       ctl_oe_o,
    input logic       hlda_o,
    input logic [1:0] state_o
);

    logic [7:0] wake_run_q;

    // Consecutive clocks spent in resuming, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_run_q <= '0;
        end else if (state_o == 2'b11) begin
            if (wake_run_q != 8'hFF) wake_run_q <= wake_run_q + 8'd1;
        end else begin
            wake_run_q <= '0;
        end
    end

    // R3
    busy_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && cyc_busy_i) |=> (state_o == 2'b00));

    // R4
    grant_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && $past(state_o) != 2'b10) |->
        ($past(state_o) == 2'b01 && $past(rdy_i || brdy_i)));

    // R5
    grant_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[1] |-> (!data_oe_o && !par_oe_o && ads_n_o && lock_n_o));

    // R7
    hlda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && hold_i) |=> hlda_o);

    // R7
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> (!addr_oe_o && !ctl_oe_o));

    // R8
    hlda_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda_o && !hold_i) |=> !hlda_o);

    // R9
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && $past(state_o) == 2'b11) |->
        (wake_run_q == 8'(RESUME_CLKS)));

    // R11
    hlda_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> (state_o == 2'b10));

endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(
    .RESUME_CLKS (RESUME_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_busy_i (cyc_busy_i),
    .rdy_i      (rdy_i),
    .brdy_i     (brdy_i),
    .hold_i     (hold_i),
    .ads_n_o    (ads_n_o),
    .lock_n_o   (lock_n_o),
    .data_oe_o  (data_oe_o),
    .par_oe_o   (par_oe_o),
    .addr_oe_o  (addr_oe_o),
    .ctl_oe_o   (ctl_oe_o),
    .hlda_o     (hlda_o),
    .state_o    (state_o)
);

// File: tb/stopclk_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected pin values for the next
// clock edge, the monitor pops and compares them shortly after that edge.
module stopclk_ctrl_tb_top;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CTL_W  = 3;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned PAR_W  = 2;
    localparam int unsigned WAKE   = 10;
    localparam logic [ADDR_W-1:0] SGA = 16'h0A5C;
    localparam logic [CTL_W-1:0]  SGC = 3'b101;

    localparam int K_STATE = 0, K_HLDA = 1, K_ADDR = 2, K_AOE = 3, K_DOE = 4,
                   K_POE = 5, K_ADS = 6, K_LOCK = 7, K_CTL = 8, K_COE = 9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, stop_req_i, cyc_busy_i, rdy_i, brdy_i, hold_i;
    logic [ADDR_W-1:0] addr_i, addr_o;
    logic [CTL_W-1:0]  ctl_i, ctl_o;
    logic              ads_n_i, lock_n_i, data_oe_i;
    logic [DATA_W-1:0] data_i, data_o;
    logic [PAR_W-1:0]  par_i, par_o;
    logic              addr_oe_o, ads_n_o, lock_n_o, ctl_oe_o;
    logic              data_oe_o, par_oe_o, hlda_o;
    logic [1:0]        state_o;

    stopclk_ctrl #(
        .ADDR_W (ADDR_W), .CTL_W (CTL_W), .DATA_W (DATA_W), .PAR_W (PAR_W),
        .RESUME_CLKS (WAKE), .SG_ADDR (SGA), .SG_CTL (SGC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .stop_req_i (stop_req_i),
        .cyc_busy_i (cyc_busy_i), .rdy_i (rdy_i), .brdy_i (brdy_i),
        .hold_i (hold_i), .addr_i (addr_i), .ctl_i (ctl_i),
        .ads_n_i (ads_n_i), .lock_n_i (lock_n_i), .data_i (data_i),
        .par_i (par_i), .data_oe_i (data_oe_i), .addr_o (addr_o),
        .addr_oe_o (addr_oe_o), .ctl_o (ctl_o), .ads_n_o (ads_n_o),
        .lock_n_o (lock_n_o), .ctl_oe_o (ctl_oe_o), .data_o (data_o),
        .par_o (par_o), .data_oe_o (data_oe_o), .par_oe_o (par_oe_o),
        .hlda_o (hlda_o), .state_o (state_o)
    );

    typedef struct {
        string       req;
        int          kind;
        int unsigned exp;
    } item_t;

    item_t sbq[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic int unsigned probe(int kind);
        case (kind)
            K_STATE: return 32'(state_o);
            K_HLDA:  return 32'(hlda_o);
            K_ADDR:  return 32'(addr_o);
            K_AOE:   return 32'(addr_oe_o);
            K_DOE:   return 32'(data_oe_o);
            K_POE:   return 32'(par_oe_o);
            K_ADS:   return 32'(ads_n_o);
            K_LOCK:  return 32'(lock_n_o);
            K_CTL:   return 32'(ctl_o);
            default: return 32'(ctl_oe_o);
        endcase
    endfunction

    // Driver side: queue an expectation for the coming clock edge.
    task automatic expect_v(string req, int kind, int unsigned v);
        sbq.push_back('{req: req, kind: kind, exp: v});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Monitor: compare every queued item a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sbq.size() > 0) begin
                item_t       it;
                int unsigned got;
                it  = sbq.pop_front();
                got = probe(it.kind);
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s (signal %0d): got %0h expected %0h",
                             it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0; stop_req_i = 1'b0; cyc_busy_i = 1'b0; rdy_i = 1'b0;
        brdy_i = 1'b0; hold_i = 1'b0; addr_i = 16'h1234; ctl_i = 3'b010;
        ads_n_i = 1'b1; lock_n_i = 1'b0; data_i = 16'hC0DE; par_i = 2'b01;
        data_oe_i = 1'b1;

        tick();
        expect_v("R1", K_STATE, 0);
        expect_v("R1", K_HLDA, 0);
        tick();
        rst_n = 1'b1;
        expect_v("R1", K_ADDR, 32'h1234);
        expect_v("R1", K_STATE, 0);

        // R3: a busy cycle defers the announcement
        tick();
        stop_req_i = 1'b1; cyc_busy_i = 1'b1;
        expect_v("R3", K_STATE, 0);
        tick();
        expect_v("R3", K_STATE, 0);

        // R2: announcement cycle values
        tick();
        cyc_busy_i = 1'b0;
        expect_v("R2", K_STATE, 1);
        expect_v("R2", K_ADS, 0);
        expect_v("R2", K_ADDR, 32'(SGA));
        expect_v("R2", K_CTL, 32'(SGC));

        // R4: ready during the strobe cycle is ignored
        tick();
        rdy_i = 1'b1;
        expect_v("R4", K_STATE, 1);
        expect_v("R2", K_ADS, 1);
        tick();
        rdy_i = 1'b0;
        expect_v("R4", K_STATE, 1);
        tick();
        brdy_i = 1'b1;
        expect_v("R4", K_STATE, 2);
        expect_v("R5", K_DOE, 0);
        expect_v("R5", K_POE, 0);
        expect_v("R5", K_ADS, 1);
        expect_v("R5", K_LOCK, 1);
        expect_v("R6", K_ADDR, 32'(SGA));

        // R6: core address change has no effect in grant
        tick();
        brdy_i = 1'b0; addr_i = 16'hBEEF; ctl_i = 3'b011;
        expect_v("R6", K_ADDR, 32'(SGA));
        expect_v("R6", K_CTL, 32'(SGC));
        expect_v("R6", K_AOE, 1);
        expect_v("R11", K_HLDA, 0);

        // R7: hold in grant
        tick();
        hold_i = 1'b1;
        expect_v("R7", K_HLDA, 1);
        expect_v("R7", K_AOE, 0);
        expect_v("R7", K_COE, 0);
        tick();
        stop_req_i = 1'b0;
        expect_v("R9", K_STATE, 2);
        expect_v("R7", K_HLDA, 1);

        // R8: hold release restores the held levels
        tick();
        hold_i = 1'b0;
        expect_v("R8", K_HLDA, 0);
        expect_v("R8", K_AOE, 1);
        expect_v("R8", K_COE, 1);
        expect_v("R8", K_ADDR, 32'(SGA));
        expect_v("R9", K_STATE, 2);

        // R9: resume countdown, with a hold pulse (R11)
        tick();
        expect_v("R9", K_STATE, 3);
        for (int k = 1; k < int'(WAKE); k++) begin
            tick();
            hold_i = (k == 3);
            expect_v("R9", K_STATE, 3);
            expect_v("R11", K_HLDA, 0);
            expect_v("R5", K_DOE, 0);
        end
        tick();
        hold_i = 1'b0;
        expect_v("R9", K_STATE, 0);
        expect_v("R9", K_ADDR, 32'hBEEF);

        // Second entry, then R10: request back during resume
        tick();
        stop_req_i = 1'b1;
        expect_v("R2", K_STATE, 1);
        tick();
        rdy_i = 1'b1;
        expect_v("R4", K_STATE, 1);
        tick();
        expect_v("R4", K_STATE, 2);
        tick();
        rdy_i = 1'b0; stop_req_i = 1'b0;
        expect_v("R9", K_STATE, 3);
        tick();
        expect_v("R9", K_STATE, 3);
        tick();
        stop_req_i = 1'b1;
        expect_v("R10", K_STATE, 1);
        expect_v("R10", K_ADS, 0);
        expect_v("R10", K_ADDR, 32'(SGA));
        tick();
        brdy_i = 1'b1;
        expect_v("R10", K_STATE, 1);
        tick();
        expect_v("R10", K_STATE, 2);

        tick();
        tick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule